// File: doc/BRIEF.md
# Six-Channel Wrap-Around System Timer

This block holds one 34-bit free-running counter that advances by one on every cycle in which a 250 ns tick enable is high. When it passes its top value it wraps to zero. Six channels share the counter. Each channel is set to either compare or capture mode, and each sees one 32-bit window of the counter. The fine window is count bits [31:0]: it steps every 250 ns and spans about 17m54s. The coarse window is count bits [33:2]: it steps every 1 µs and spans about 1h11m35s.

A compare channel is single-shot. Software writes a target and the channel raises its event line for exactly one cycle when its window reaches that target. A target that lies a little behind the current window is treated as already due and fires at once, so a late write does not wait for a full wrap. "A little behind" means at most 2^22 window units. A capture channel synchronises its external input, latches its window on a rising edge and raises a pending flag. Software reads the latched value through a channel select and clears the flag with a write.

A load strobe replaces the whole 34-bit count, for example to align the count with a slower real-time base. Every armed compare channel then applies the past-window rule to the new count. A target the load jumped over fires on the next cycle, and a target outside the window stays armed with no event.

Top module: `mc_wrap_timer`

## Requirements
- R1: While and after a synchronous active-high reset, all event lines, all pending flags and the capture read value are 0. The count is 0. Every channel is in compare mode with the fine window and is not armed.
- R2: Each clock edge with tick_en high and load_en low adds one to the 34-bit count. The value 2^34-1 wraps to 0. With both low, the count holds.
- R3: An edge with load_en high sets the count to load_val. At that edge the load takes priority over tick_en.
- R4: Each channel uses the fine window (count[31:0]) or the coarse window (count[33:2]) for both compare and capture.
- R5: A compare-mode channel armed with target T raises its event line for one cycle in the cycle after the edge at which its window equals T. It then disarms, so no further event comes without a new write.
- R6: Writing target V at an edge where (window − V) mod 2^32 ≤ 2^22 raises the event line in the next cycle and leaves the channel unarmed. A value of 2^22+1 or more units behind arms the channel with no event.
- R7: After a load, every armed channel is evaluated at the next edge against the new count with the R6 rule. A target the load jumped over fires in the cycle after that. Any other target stays armed with no event.
- R8: In capture mode, a rising edge of cap_in[i] is passed through a two-stage synchroniser plus one edge register. It latches the channel's window at the third edge after cap_in rises, taking the value the count held just before that edge. The same edge sets cap_pend[i]. rd_cap shows the latched value of channel rd_ch.
- R9: Operation 2 (clear) clears cap_pend[i]. If a capture lands at the same edge as the clear, the capture wins and the flag stays set.
- R10: A compare write to a capture-mode channel is ignored, and so is a capture edge on a compare-mode channel. Operation 0 (configure) sets the mode from wr_data[0] (0 compare, 1 capture) and the window from wr_data[1] (0 fine, 1 coarse). It also disarms the channel and clears its pending flag. Operation 3, and any channel number of 6 or more, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 250 ns advance enable for the count |
| load_en | input | 1 | Load strobe for the full count |
| load_val | input | 34 | Count value applied on load |
| cap_in | input | 6 | Asynchronous capture inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 3 | Channel addressed by the write |
| wr_op | input | 2 | 0 configure, 1 compare target, 2 clear pending, 3 none |
| wr_data | input | 32 | Configuration bits or compare target |
| rd_ch | input | 3 | Channel whose capture value is shown |
| rd_cap | output | 32 | Latched capture value of channel rd_ch |
| cap_pend | output | 6 | Capture pending flags |
| evt | output | 6 | One-cycle event lines |

## Verification
The count reacts to tick and load at the next edge. A compare event, whether immediate, matched or re-evaluated after a load, appears in the cycle after the edge at which the decision is made, so a match shows one cycle after the count reaches the target. A capture needs three edges after its input rises. A behavioural reference model in the bench steps once per clock edge with the same inputs and builds each of these delays into its own updates. Outputs are compared about 2 ns after each edge. The directed checks count negative clock edges from each stimulus to the exact cycle in which a result is due and check it there.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

    localparam int CNT_W        = 34;
    localparam int SLICE_W      = 32;
    localparam int COARSE_SHIFT = CNT_W - SLICE_W;
    localparam int WIN_LOG2     = 22;

    typedef logic [CNT_W-1:0]   count_t;
    typedef logic [SLICE_W-1:0] slice_t;

    localparam slice_t WIN_SPAN = slice_t'(1) << WIN_LOG2;

    typedef enum logic [1:0] {
        OP_CFG  = 2'd0,
        OP_CMP  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic {
        MODE_CMP = 1'b0,
        MODE_CAP = 1'b1
    } mode_e;

    typedef enum logic {
        RES_FINE   = 1'b0,
        RES_COARSE = 1'b1
    } res_e;

    typedef struct packed {
        mode_e mode;
        res_e  res;
    } ch_cfg_t;

    typedef struct packed {
        logic   cfg;
        logic   cmp;
        logic   clr;
        slice_t data;
    } ch_wr_t;

    function automatic slice_t take_slice(count_t c, res_e r);
        return (r == RES_COARSE) ? c[CNT_W-1:COARSE_SHIFT] : c[SLICE_W-1:0];
    endfunction

    function automatic logic in_recent_past(slice_t now, slice_t tgt);
        slice_t lag;
        lag = now - tgt;
        return lag <= WIN_SPAN;
    endfunction

endpackage

// File: rtl/mwt_sync.sv
module mwt_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] rise
);

    logic [STAGES:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], d};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0)); // R8

endmodule

// File: rtl/mwt_counter.sv
module mwt_counter
    import mwt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_en,
    input  logic   load_en,
    input  count_t load_val,
    output count_t cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (tick_en) begin
            cnt <= cnt + count_t'(1);
        end
    end

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !load_en) |=> (cnt == $past(cnt) + count_t'(1))); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !load_en) |=> $stable(cnt)); // R2

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cnt == $past(load_val))); // R3

endmodule

// File: rtl/mwt_channel.sv
module mwt_channel
    import mwt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  count_t cnt,
    input  ch_wr_t wr,
    input  logic   cap_rise,
    output logic   evt,
    output logic   pend,
    output slice_t cap_val
);

    ch_cfg_t cfg_q;
    logic    armed_q;
    slice_t  tgt_q;
    logic    evt_q;
    logic    pend_q;
    slice_t  cap_q;

    slice_t  now;
    logic    cmp_ok;
    logic    wr_past;
    logic    arm_due;
    logic    cap_ok;

    assign now     = take_slice(cnt, cfg_q.res);
    assign cmp_ok  = wr.cmp && (cfg_q.mode == MODE_CMP);
    assign wr_past = in_recent_past(now, wr.data);
    assign arm_due = armed_q && in_recent_past(now, tgt_q);
    assign cap_ok  = cap_rise && (cfg_q.mode == MODE_CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{mode: MODE_CMP, res: RES_FINE};
            armed_q <= 1'b0;
            tgt_q   <= '0;
            evt_q   <= 1'b0;
            pend_q  <= 1'b0;
            cap_q   <= '0;
        end else begin
            evt_q <= 1'b0;
            if (wr.cfg) begin
                cfg_q.mode <= mode_e'(wr.data[0]);
                cfg_q.res  <= res_e'(wr.data[1]);
                armed_q    <= 1'b0;
                pend_q     <= 1'b0;
            end else begin
                if (cmp_ok) begin
                    if (wr_past) begin
                        evt_q   <= 1'b1;
                        armed_q <= 1'b0;
                    end else begin
                        armed_q <= 1'b1;
                        tgt_q   <= wr.data;
                    end
                end else if (arm_due) begin
                    evt_q   <= 1'b1;
                    armed_q <= 1'b0;
                end
                if (cap_ok) begin
                    cap_q  <= now;
                    pend_q <= 1'b1;
                end else if (wr.clr) begin
                    pend_q <= 1'b0;
                end
            end
        end
    end

    assign evt     = evt_q;
    assign pend    = pend_q;
    assign cap_val = cap_q;

    AST_EVT_SOURCE: assert property (@(posedge clk) disable iff (rst)
        evt_q |-> $past(armed_q || cmp_ok)); // R5

    AST_ARM_FIRE: assert property (@(posedge clk) disable iff (rst)
        (arm_due && !wr.cfg && !cmp_ok) |=> (evt_q && !armed_q)); // R5

    AST_IMM_FIRE: assert property (@(posedge clk) disable iff (rst)
        (cmp_ok && !wr.cfg && wr_past) |=> (evt_q && !armed_q)); // R6

    AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !in_recent_past(now, tgt_q) && !wr.cfg && !cmp_ok) |=> !evt_q); // R7

    AST_CAP_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> (cfg_q.mode == MODE_CAP)); // R10

endmodule

// File: rtl/mc_wrap_timer.sv
module mc_wrap_timer
    import mwt_pkg::*;
#(
    parameter  int NCH         = 6,
    parameter  int SYNC_STAGES = 2,
    localparam int CH_W        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               load_en,
    input  logic [CNT_W-1:0]   load_val,
    input  logic [NCH-1:0]     cap_in,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_ch,
    input  logic [1:0]         wr_op,
    input  logic [SLICE_W-1:0] wr_data,
    input  logic [CH_W-1:0]    rd_ch,
    output logic [SLICE_W-1:0] rd_cap,
    output logic [NCH-1:0]     cap_pend,
    output logic [NCH-1:0]     evt
);

    count_t                   cnt;
    logic [NCH-1:0]           cap_rise;
    logic [NCH-1:0][SLICE_W-1:0] cap_arr;
    op_e                      op;

    assign op = op_e'(wr_op);

    mwt_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt      (cnt)
    );

    mwt_sync #(
        .W      (NCH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    (cap_in),
        .rise (cap_rise)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ch_wr_t ch_wr;
        logic   hit;

        assign hit        = wr_en && (wr_ch == CH_W'(i));
        assign ch_wr.cfg  = hit && (op == OP_CFG);
        assign ch_wr.cmp  = hit && (op == OP_CMP);
        assign ch_wr.clr  = hit && (op == OP_CLR);
        assign ch_wr.data = wr_data;

        mwt_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .cnt      (cnt),
            .wr       (ch_wr),
            .cap_rise (cap_rise[i]),
            .evt      (evt[i]),
            .pend     (cap_pend[i]),
            .cap_val  (cap_arr[i])
        );
    end

    always_comb begin
        rd_cap = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CH_W'(i)) begin
                rd_cap = cap_arr[i];
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> ((evt == '0) && (cap_pend == '0))); // R1

endmodule

// File: tb/mc_wrap_timer_tb.sv
module mc_wrap_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic        load_en;
    logic [33:0] load_val;
    logic [5:0]  cap_in;
    logic        wr_en;
    logic [2:0]  wr_ch;
    logic [1:0]  wr_op;
    logic [31:0] wr_data;
    logic [2:0]  rd_ch;
    logic [31:0] rd_cap;
    logic [5:0]  cap_pend;
    logic [5:0]  evt;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    mc_wrap_timer u_dut (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load_en  (load_en),
        .load_val (load_val),
        .cap_in   (cap_in),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_op    (wr_op),
        .wr_data  (wr_data),
        .rd_ch    (rd_ch),
        .rd_cap   (rd_cap),
        .cap_pend (cap_pend),
        .evt      (evt)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [33:0] m_cnt;
    bit          m_mode [6];
    bit          m_res  [6];
    bit          m_arm  [6];
    logic [31:0] m_tgt  [6];
    logic [31:0] m_cap  [6];
    logic [5:0]  m_pend;
    logic [5:0]  m_evt;
    logic [5:0]  m_s1, m_s2, m_s3, m_rise;

    function automatic logic [31:0] mslice(int i);
        return m_res[i] ? m_cnt[33:2] : m_cnt[31:0];
    endfunction

    function automatic bit win(logic [31:0] now, logic [31:0] t);
        logic [31:0] d;
        d = now - t;
        return d <= 32'h0040_0000;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_pend = '0; m_evt = '0;
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
            for (int i = 0; i < 6; i++) begin
                m_mode[i] = 0; m_res[i] = 0; m_arm[i] = 0;
                m_tgt[i] = '0; m_cap[i] = '0;
            end
        end else begin
            m_rise = m_s2 & ~m_s3;
            for (int i = 0; i < 6; i++) begin
                bit          sel;
                logic [31:0] now;
                sel = wr_en && (int'(wr_ch) == i);
                now = mslice(i);
                m_evt[i] = 1'b0;
                if (sel && wr_op == 2'd0) begin
                    m_mode[i] = wr_data[0];
                    m_res[i]  = wr_data[1];
                    m_arm[i]  = 0;
                    m_pend[i] = 1'b0;
                end else begin
                    if (sel && wr_op == 2'd1 && !m_mode[i]) begin
                        if (win(now, wr_data)) begin
                            m_evt[i] = 1'b1; m_arm[i] = 0;
                        end else begin
                            m_arm[i] = 1; m_tgt[i] = wr_data;
                        end
                    end else if (m_arm[i] && win(now, m_tgt[i])) begin
                        m_evt[i] = 1'b1; m_arm[i] = 0;
                    end
                    if (m_mode[i] && m_rise[i]) begin
                        m_cap[i] = now; m_pend[i] = 1'b1;
                    end else if (sel && wr_op == 2'd2) begin
                        m_pend[i] = 1'b0;
                    end
                end
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
            if (load_en) m_cnt = load_val;
            else if (tick_en) m_cnt = m_cnt + 34'd1;
        end
        #2;
        if (!done) begin
            chk(evt === m_evt, "R5 model evt", evt, m_evt);
            chk(cap_pend === m_pend, "R8 model pend", cap_pend, m_pend);
            chk(rd_cap === ((rd_ch < 6) ? m_cap[rd_ch] : 32'h0), "R8 model rd_cap",
                rd_cap, (rd_ch < 6) ? m_cap[rd_ch] : 32'h0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int ch, input int op, input logic [31:0] d);
        wr_en = 1'b1; wr_ch = 3'(ch); wr_op = 2'(op); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ld(input logic [33:0] v);
        load_en = 1'b1; load_val = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL R2 watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        int first;
        int hits;
        rst = 1'b1; tick_en = 0; load_en = 0; load_val = '0; cap_in = '0;
        wr_en = 0; wr_ch = '0; wr_op = 2'd3; wr_data = '0; rd_ch = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(evt == 6'h0, "R1 evt", evt, 0);
        chk(cap_pend == 6'h0, "R1 pend", cap_pend, 0);
        chk(rd_cap == 32'h0, "R1 rd_cap", rd_cap, 0);

        // configuration (R10 encodings)
        wr(0, 0, 32'h0); wr(1, 0, 32'h2); wr(2, 0, 32'h1);
        wr(3, 0, 32'h3); wr(4, 0, 32'h0); wr(5, 0, 32'h1);

        // R3 load, R4 window selection through capture
        ld(34'h2_0000_0010);
        cap_in[3:2] = 2'b11;
        cyc(4);
        rd_ch = 3'd2; #1;
        chk(rd_cap == 32'h0000_0010, "R3 load fine capture", rd_cap, 32'h10);
        rd_ch = 3'd3; #1;
        chk(rd_cap == 32'h8000_0004, "R4 coarse capture", rd_cap, 32'h8000_0004);
        chk(cap_pend[3:2] == 2'b11, "R8 pending set", cap_pend, 6'h0c);
        cap_in = '0;
        @(negedge clk);
        wr(2, 2, 32'h0);
        chk(cap_pend[2] == 1'b0, "R9 clear", cap_pend[2], 0);

        // R2 tick counting
        tick_en = 1'b1; cyc(10); tick_en = 1'b0;
        cap_in[2] = 1'b1; cyc(4); cap_in[2] = 1'b0;
        rd_ch = 3'd2; #1;
        chk(rd_cap == 32'h0000_001A, "R2 ten ticks", rd_cap, 32'h1a);
        @(negedge clk);

        // R5 future compare, single shot
        wr(0, 1, 32'h20);
        chk(evt[0] == 1'b0, "R5 no early event", evt[0], 0);
        tick_en = 1'b1;
        first = 0; hits = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (evt[0]) begin
                hits++;
                if (first == 0) first = k;
            end
        end
        tick_en = 1'b0;
        chk(first == 7, "R5 match cycle", first, 7);
        chk(hits == 1, "R5 single shot", hits, 1);

        // R6 past window (fine slice now 0x2E)
        wr(4, 1, 32'h2E - 32'h0040_0000);
        chk(evt[4] == 1'b1, "R6 edge of window fires", evt[4], 1);
        wr(4, 1, 32'h2E);
        chk(evt[4] == 1'b1, "R6 equal fires", evt[4], 1);
        wr(4, 1, 32'h2E - 32'h0040_0001);
        chk(evt[4] == 1'b0, "R6 outside window arms", evt[4], 0);
        cyc(3);
        chk(evt[4] == 1'b0, "R6 stays armed quietly", evt[4], 0);

        // R7 load re-evaluation
        wr(0, 1, 32'h2E + 32'd50);
        ld(34'h2_0000_002E + 34'd100);
        chk(evt[0] == 1'b0, "R7 not at load edge", evt[0], 0);
        @(negedge clk);
        chk(evt[0] == 1'b1, "R7 skipped target fires", evt[0], 1);
        chk(evt[4] == 1'b0, "R7 far target stays quiet", evt[4], 0);
        cyc(3);
        chk(evt[4] == 1'b0, "R7 far target still quiet", evt[4], 0);

        // R3 priority, R7 re-eval of ch4, R2 wrap
        tick_en = 1'b1;
        ld(34'h3_FFFF_FFFE);
        @(negedge clk);
        chk(evt[4] == 1'b1, "R7 load into window fires", evt[4], 1);
        cyc(2);
        tick_en = 1'b0;
        cap_in[3:2] = 2'b11; cyc(4); cap_in[3:2] = 2'b00;
        rd_ch = 3'd2; #1;
        chk(rd_cap == 32'h1, "R3 load beats tick, R2 wrap", rd_cap, 1);
        rd_ch = 3'd3; #1;
        chk(rd_cap == 32'h0, "R4 coarse after wrap", rd_cap, 0);
        @(negedge clk);

        // R10 mode isolation
        wr(2, 1, 32'h1);
        chk(evt[2] == 1'b0, "R10 compare ignored in capture mode", evt[2], 0);
        cyc(2);
        chk(evt == 6'h0, "R10 no late event", evt, 0);
        cap_in[0] = 1'b1; cyc(4); cap_in[0] = 1'b0;
        chk(cap_pend[0] == 1'b0, "R10 capture ignored in compare mode", cap_pend[0], 0);
        wr(3, 0, 32'h3);
        chk(cap_pend[3] == 1'b0, "R10 configure clears pending", cap_pend[3], 0);
        wr(6, 1, 32'h1);
        chk(evt == 6'h0, "R10 channel 6 ignored", evt, 0);

        // R9 capture wins over clear
        wr(2, 2, 32'h0);
        cap_in[2] = 1'b1;
        cyc(2);
        wr(2, 2, 32'h0);
        chk(cap_pend[2] == 1'b1, "R9 set over clear", cap_pend[2], 1);
        cap_in[2] = 1'b0;
        cyc(3);

        // random phase, checked by the model every cycle
        for (int n = 0; n < 4000; n++) begin
            int ch;
            int cls;
            tick_en = ($urandom % 4) != 0;
            load_en = ($urandom % 150) == 0;
            if (($urandom % 2) == 0) load_val = m_cnt + 34'(($urandom % 64) * 16);
            else load_val = {2'($urandom), $urandom};
            for (int b = 0; b < 6; b++)
                if (($urandom % 8) == 0) cap_in[b] = ~cap_in[b];
            ch = $urandom % 7;
            wr_en = ($urandom % 5) == 0;
            wr_ch = 3'(ch);
            wr_op = 2'($urandom);
            rd_ch = 3'($urandom % 6);
            if (wr_op == 2'd0) begin
                wr_data = 32'($urandom % 4);
            end else begin
                cls = $urandom % 4;
                wr_data = (ch < 6) ? mslice(ch) : 32'h0;
                case (cls)
                    0: wr_data = wr_data + 32'($urandom % 40);
                    1: wr_data = wr_data - 32'h0040_0000 + 32'($urandom % 3) - 32'd1;
                    2: wr_data = wr_data - 32'($urandom % 16);
                    default: wr_data = $urandom;
                endcase
            end
            @(negedge clk);
        end
        wr_en = 1'b0; load_en = 1'b0; tick_en = 1'b0;
        cyc(2);
        finish_run();
    end

endmodule